// File: doc/BRIEF.md
# Capture/Waveform Timer Channel

This block is one timer channel built around an up-counter with three reference registers, A, B and C. A mode bit selects how the channel works. In capture mode, chosen transitions of the `tioa_in` pin copy the running count into A or B, so software can measure pulse widths and periods. In waveform mode, software programs A, B and C. Compare matches then drive two output pins as pulse-width-modulated waves that share one period.

The counter advances on each clock cycle in which `tick_en` is high. Any of three causes returns it to zero: a software trigger written to the control register, the `sync_in` input, or a tick taken while the count equals C. Software reaches the channel through a simple synchronous register port. A status register collects compare and capture events, and those events are gated by an enable mask onto a single interrupt line.

Top module: `tmr_chan`

## Requirements
- R1: The counter is 16 bits wide. It advances by one on each clock edge where `tick_en` is high, and holds its value when `tick_en`, `sync_in` and the software trigger are all low.
- R2: A tick taken while the count equals register C makes the count 0 at that edge, and counting continues from 0.
- R3: Writing the control register (offset 0x00) with bit 0 set makes the count 0 at that edge. This overrides a simultaneous tick and a simultaneous C match, and the next tick gives 1. A control write with bit 0 clear leaves the count alone.
- R4: `sync_in` high at a clock edge makes the count 0 at that edge, whatever `tick_en` is.
- R5: The mode register (offset 0x04) holds bits [4:0]: bit 0 set selects waveform mode and clear selects capture mode; bits [2:1] pick the edge that loads A and bits [4:3] the edge that loads B, coded 00 none, 01 rising, 10 falling, 11 both. It reads back exactly those bits.
- R6: In capture mode, `tioa_in` passes through two synchronising flip-flops. A selected edge then copies the current count into A or B and sets status bit 3 (A loaded) or bit 4 (B loaded). In waveform mode, edges on `tioa_in` load nothing.
- R7: Bus writes to A (0x14) and B (0x18) take effect only in waveform mode and are ignored in capture mode.
- R8: In waveform mode, `tioa_oe` is high. `tioa_out` goes high one edge after a tick at count A, `tiob_out` goes high one edge after a tick at count B, and both go low one edge after a tick at count C, with C winning a tie. In capture mode `tioa_oe` is low and both outputs are low from the second edge onward.
- R9: Status (0x20) bits are: 0 A compare and 1 B compare (each a tick at that count, waveform mode only), 2 C compare (both modes), 3 A loaded, 4 B loaded. Reading status clears the flags, but an event in the same cycle stays set.
- R10: The interrupt enable register (0x24) holds 5 bits. `irq` is high exactly when some status bit and its enable bit are both set.
- R11: Register C (0x1C) keeps the low 16 bits written. The count reads at 0x10. Unused bits and unmapped offsets read 0.
- R12: After reset, all registers, the count, the status and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_en | input | 1 | Counter advance enable |
| sync_in | input | 1 | External counter reset |
| tioa_in | input | 1 | Capture input pin level |
| tioa_out | output | 1 | Waveform output A |
| tioa_oe | output | 1 | Drive enable for pin A (waveform mode) |
| tiob_out | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a collision: a software trigger and a C match landing on the same edge. Two others are similar: a match with A on the same tick as C, and a capture edge racing a status read. The bench stops the counter by holding `tick_en` low, steps it an exact number of ticks to the compare value, and then drives the trigger write and the tick on one shared cycle. Capture values are made exact by freezing the count before moving `tioa_in`, and by waiting out the synchroniser before reading A and B back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RA   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_RB   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RC   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_STS  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h24;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // bit 0: waveform, bits 2:1 load-A edge, bits 4:3 load-B edge
    typedef struct packed {
        edge_sel_e ld_b;
        edge_sel_e ld_a;
        logic      wave;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // status bit positions
    localparam int ST_CMPA = 0;
    localparam int ST_CMPB = 1;
    localparam int ST_CMPC = 2;
    localparam int ST_LDA  = 3;
    localparam int ST_LDB  = 4;
    localparam int ST_W    = 5;
endpackage

// File: rtl/tmr_edge_cap.sv
module tmr_edge_cap
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  logic      arm,
    input  edge_sel_e sel_a,
    input  edge_sel_e sel_b,
    output logic      hit_a,
    output logic      hit_b
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } st_t;

    st_t  s_d, s_q;
    logic rise, fall;

    function automatic logic pick(edge_sel_e sel, logic r, logic f);
        case (sel)
            EDGE_RISE: return r;
            EDGE_FALL: return f;
            EDGE_BOTH: return r | f;
            default:   return 1'b0;
        endcase
    endfunction

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_N-2:0], pin_i};
        s_d.prev = s_q.sync[SYNC_N-1];
        rise     = s_q.sync[SYNC_N-1] & ~s_q.prev;
        fall     = ~s_q.sync[SYNC_N-1] & s_q.prev;
        hit_a    = arm & pick(sel_a, rise, fall);
        hit_b    = arm & pick(sel_b, rise, fall);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          clr,
    input  logic [CW-1:0] ra,
    input  logic [CW-1:0] rb,
    input  logic [CW-1:0] rc,
    output logic [CW-1:0] cnt,
    output logic          hit_a,
    output logic          hit_b,
    output logic          hit_c
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        hit_a = tick_en && (s_q.cnt == ra);
        hit_b = tick_en && (s_q.cnt == rb);
        hit_c = tick_en && (s_q.cnt == rc);
        s_d   = s_q;
        if (clr)          s_d.cnt = '0;
        else if (tick_en) s_d.cnt = hit_c ? '0 : s_q.cnt + CW'(1);
        cnt   = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_a,
    input  logic set_b,
    input  logic clr,
    output logic out_a,
    output logic out_b
);
    typedef struct packed {
        logic a;
        logic b;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.a = 1'b0;
            s_d.b = 1'b0;
        end else if (clr) begin
            s_d.a = 1'b0;
            s_d.b = 1'b0;
        end else begin
            if (set_a) s_d.a = 1'b1;
            if (set_b) s_d.b = 1'b1;
        end
        out_a = s_q.a;
        out_b = s_q.b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int DW     = 32,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tick_en,
    input  logic              sync_in,
    input  logic              tioa_in,
    output logic              tioa_out,
    output logic              tioa_oe,
    output logic              tiob_out,
    output logic              irq
);
    typedef struct packed {
        mode_t           mode;
        logic [CW-1:0]   ra;
        logic [CW-1:0]   rb;
        logic [CW-1:0]   rc;
        logic [ST_W-1:0] sts;
        logic [ST_W-1:0] ien;
    } regs_t;

    regs_t           r_d, r_q;
    logic [CW-1:0]   cnt;
    logic            hit_a, hit_b, hit_c;
    logic            cap_a, cap_b;
    logic            wave;
    logic            sw_trig, rd_sts;
    logic [ST_W-1:0] ev;
    logic [CW-1:0]   ra_v, rc_v;
    logic [ST_W-1:0] sts_v;

    function automatic logic wr_at(logic sel, logic wr, logic [ADDR_W-1:0] a,
                                   logic [ADDR_W-1:0] ofs);
        return sel && wr && (a == ofs);
    endfunction

    assign wave    = r_q.mode.wave;
    assign tioa_oe = wave;
    assign sw_trig = wr_at(bus_sel, bus_wr, bus_addr, OFS_CTRL) && bus_wdata[0];
    assign rd_sts  = bus_sel && !bus_wr && (bus_addr == OFS_STS);
    assign ra_v    = r_q.ra;
    assign rc_v    = r_q.rc;
    assign sts_v   = r_q.sts;

    tmr_count #(.CW(CW)) i_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .clr    (sw_trig | sync_in),
        .ra     (r_q.ra),
        .rb     (r_q.rb),
        .rc     (r_q.rc),
        .cnt    (cnt),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .hit_c  (hit_c)
    );

    tmr_edge_cap #(.SYNC_N(SYNC_N)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i(tioa_in),
        .arm  (~wave),
        .sel_a(r_q.mode.ld_a),
        .sel_b(r_q.mode.ld_b),
        .hit_a(cap_a),
        .hit_b(cap_b)
    );

    tmr_wave i_wave (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wave),
        .set_a(hit_a),
        .set_b(hit_b),
        .clr  (hit_c),
        .out_a(tioa_out),
        .out_b(tiob_out)
    );

    always_comb begin
        ev          = '0;
        ev[ST_CMPA] = hit_a & wave;
        ev[ST_CMPB] = hit_b & wave;
        ev[ST_CMPC] = hit_c;
        ev[ST_LDA]  = cap_a;
        ev[ST_LDB]  = cap_b;

        r_d = r_q;
        if (wr_at(bus_sel, bus_wr, bus_addr, OFS_MODE)) r_d.mode = bus_wdata[MODE_W-1:0];
        if (wr_at(bus_sel, bus_wr, bus_addr, OFS_RC))   r_d.rc   = bus_wdata[CW-1:0];
        if (wr_at(bus_sel, bus_wr, bus_addr, OFS_IEN))  r_d.ien  = bus_wdata[ST_W-1:0];
        if (wave) begin
            if (wr_at(bus_sel, bus_wr, bus_addr, OFS_RA)) r_d.ra = bus_wdata[CW-1:0];
            if (wr_at(bus_sel, bus_wr, bus_addr, OFS_RB)) r_d.rb = bus_wdata[CW-1:0];
        end else begin
            if (cap_a) r_d.ra = cnt;
            if (cap_b) r_d.rb = cnt;
        end
        r_d.sts = (rd_sts ? '0 : r_q.sts) | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata[MODE_W-1:0] = r_q.mode;
            OFS_CNT:  bus_rdata[CW-1:0]     = cnt;
            OFS_RA:   bus_rdata[CW-1:0]     = r_q.ra;
            OFS_RB:   bus_rdata[CW-1:0]     = r_q.rb;
            OFS_RC:   bus_rdata[CW-1:0]     = r_q.rc;
            OFS_STS:  bus_rdata[ST_W-1:0]   = r_q.sts;
            OFS_IEN:  bus_rdata[ST_W-1:0]   = r_q.ien;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = |(r_q.sts & r_q.ien);
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trig,
    input logic            rd_sts,
    input logic            tick_en,
    input logic            sync_in,
    input logic [CW-1:0]   cnt,
    input logic [CW-1:0]   ra,
    input logic [CW-1:0]   rc,
    input logic            wave,
    input logic            tioa_out,
    input logic            tiob_out,
    input logic [ST_W-1:0] sts
);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !sync_in && !trig) |=> $stable(cnt));

    p_cmatch_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == rc) |=> (cnt == '0));

    p_trig_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0));

    p_sync_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (cnt == '0));

    p_capture_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wave |=> (!tioa_out && !tiob_out));

    p_a_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wave && tick_en && cnt == ra && cnt != rc) |=> tioa_out);

    p_c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == rc) |=> (!tioa_out && !tiob_out));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !tick_en) |=> (sts[ST_CMPC:ST_CMPA] == '0));
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (sw_trig),
    .rd_sts  (rd_sts),
    .tick_en (tick_en),
    .sync_in (sync_in),
    .cnt     (cnt),
    .ra      (ra_v),
    .rc      (rc_v),
    .wave    (wave),
    .tioa_out(tioa_out),
    .tiob_out(tiob_out),
    .sts     (sts_v)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0, sync_in = 1'b0, tioa_in = 1'b0;
    logic        tioa_out, tioa_oe, tiob_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_chan i_tmr_chan (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .sync_in(sync_in), .tioa_in(tioa_in),
        .tioa_out(tioa_out), .tioa_oe(tioa_oe), .tiob_out(tiob_out), .irq(irq)
    );

    localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_CNT = 6'h10, A_RA = 6'h14,
                           A_RB = 6'h18, A_RC = 6'h1C, A_STS = 6'h20, A_IEN = 6'h24;

    typedef struct packed {
        logic        wr;
        logic [5:0]  a;
        logic [31:0] d;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, A_RC,   32'h0000_0009, "R2"},
        '{1'b0, A_RC,   32'h0000_0009, "R2"},
        '{1'b1, A_IEN,  32'h0000_00FF, "R0"},
        '{1'b0, A_IEN,  32'h0000_001F, "R0"},
        '{1'b1, A_RA,   32'h0000_1234, "R7"},
        '{1'b0, A_RA,   32'h0000_0000, "R7"},
        '{1'b1, A_RB,   32'h0000_0055, "R7"},
        '{1'b0, A_RB,   32'h0000_0000, "R7"},
        '{1'b1, A_MODE, 32'hFFFF_FFE1, "R5"},
        '{1'b0, A_MODE, 32'h0000_0001, "R5"},
        '{1'b1, A_RA,   32'h0000_0003, "R7"},
        '{1'b0, A_RA,   32'h0000_0003, "R7"},
        '{1'b1, A_RB,   32'h0000_0006, "R7"},
        '{1'b0, A_RB,   32'h0000_0006, "R7"},
        '{1'b1, A_RC,   32'h0001_2345, "R1"},
        '{1'b0, A_RC,   32'h0000_2345, "R1"},
        '{1'b1, A_RC,   32'h0000_0009, "R1"},
        '{1'b0, A_CNT,  32'h0000_0000, "R1"},
        '{1'b0, 6'h08,  32'h0000_0000, "R1"},
        '{1'b1, A_MODE, 32'h0000_0000, "R5"},
        '{1'b0, A_MODE, 32'h0000_0000, "R5"},
        '{1'b1, A_IEN,  32'h0000_0000, "R0"}
    };
    // table tags: "R0" stands for R10, "R1" in RC/CNT rows for R11, "R2" for C width rows (R11)

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(A_CNT, v);  check("R12 count", v, 0);
        rd(A_MODE, v); check("R12 mode", v, 0);
        rd(A_STS, v);  check("R12 status", v, 0);
        check("R12 irq", {31'd0, irq}, 0);
        check("R12 tioa_out", {31'd0, tioa_out}, 0);
        check("R12 tiob_out", {31'd0, tiob_out}, 0);
        check("R12 tioa_oe", {31'd0, tioa_oe}, 0);

        // register table: R5 R7 R10 R11
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
            else begin
                rd(VEC[i].a, v);
                check($sformatf("table %0d (%s)", i, VEC[i].tag), v, VEC[i].d);
            end
        end

        // R1 R2: count with C=4, 7 ticks -> 2, hold when idle
        wr(A_RC, 4);
        ticks(7);
        rd(A_CNT, v); check("R2 wrap at C", v, 2);
        idle(3);
        rd(A_CNT, v); check("R1 hold without tick", v, 2);
        // R9: only C compare in capture mode, read clears
        rd(A_STS, v); check("R9 capture status", v, 32'h04);
        rd(A_STS, v); check("R9 read clears", v, 0);

        // R10 interrupt gating
        wr(A_IEN, 32'h04);
        ticks(5);
        check("R10 irq enabled", {31'd0, irq}, 1);
        wr(A_IEN, 32'h01);
        check("R10 irq masked", {31'd0, irq}, 0);
        rd(A_STS, v); check("R9 status held", v, 32'h04);
        wr(A_IEN, 32'h04);
        check("R10 irq after clear", {31'd0, irq}, 0);
        wr(A_IEN, 0);

        // R3 software trigger
        wr(A_CTRL, 1);
        rd(A_CNT, v); check("R3 trigger", v, 0);
        ticks(3);
        wr(A_CTRL, 32'h2);
        rd(A_CNT, v); check("R3 bit0 clear no effect", v, 3);

        // R3 trigger together with C match
        wr(A_RC, 2);
        wr(A_CTRL, 1);
        ticks(2);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 1;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_CNT, v); check("R3 trigger with C match", v, 0);
        ticks(1);
        rd(A_CNT, v); check("R3 counts from zero", v, 1);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 1;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_CNT, v); check("R3 trigger beats tick", v, 0);

        // R4 sync input
        ticks(1);
        @(negedge clk);
        sync_in = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        sync_in = 1'b0; tick_en = 1'b0;
        rd(A_CNT, v); check("R4 sync reset", v, 0);
        rd(A_STS, v);

        // R6 capture: A on rise, B on fall (mode 0x12)
        wr(A_RC, 100);
        ticks(7);
        wr(A_MODE, 32'h12);
        @(negedge clk); tioa_in = 1'b1;
        idle(5);
        rd(A_RA, v); check("R6 rise loads A", v, 7);
        rd(A_RB, v); check("R6 B untouched on rise", v, 6);
        ticks(4);
        @(negedge clk); tioa_in = 1'b0;
        idle(5);
        rd(A_RB, v); check("R6 fall loads B", v, 11);
        rd(A_RA, v); check("R6 A untouched on fall", v, 7);
        rd(A_STS, v); check("R6 load flags", v, 32'h18);
        // R5 both edges on A, none on B (mode 0x06)
        wr(A_MODE, 32'h06);
        ticks(2);
        @(negedge clk); tioa_in = 1'b1;
        idle(5);
        rd(A_RA, v); check("R5 both-edge rise", v, 13);
        ticks(1);
        @(negedge clk); tioa_in = 1'b0;
        idle(5);
        rd(A_RA, v); check("R5 both-edge fall", v, 14);
        rd(A_RB, v); check("R5 none keeps B", v, 11);
        rd(A_STS, v); check("R6 only A flag", v, 32'h08);

        // R6 no capture in waveform mode
        wr(A_MODE, 32'h07);
        wr(A_RA, 50);
        @(negedge clk); tioa_in = 1'b1;
        idle(5);
        rd(A_RA, v); check("R6 no load in waveform", v, 50);
        rd(A_STS, v); check("R6 no flag in waveform", v, 0);
        @(negedge clk); tioa_in = 1'b0;
        idle(5);

        // R8 waveform A=3 B=6 C=9
        wr(A_MODE, 32'h01);
        wr(A_RA, 3);
        wr(A_RB, 6);
        wr(A_RC, 9);
        wr(A_CTRL, 1);
        rd(A_STS, v); check("R9 quiet before waveform", v, 0);
        check("R8 oe in waveform", {31'd0, tioa_oe}, 1);
        ticks(4);
        check("R8 A set", {30'd0, tioa_out, tiob_out}, 32'h2);
        ticks(3);
        check("R8 B set", {30'd0, tioa_out, tiob_out}, 32'h3);
        ticks(3);
        check("R8 C clears", {30'd0, tioa_out, tiob_out}, 32'h0);
        rd(A_CNT, v); check("R2 period end", v, 0);
        rd(A_STS, v); check("R9 waveform flags", v, 32'h07);

        // R8 tie: A equals C, C wins
        wr(A_RA, 9);
        ticks(10);
        check("R8 C wins tie", {31'd0, tioa_out}, 0);

        // R8 leaving waveform forces outputs low
        wr(A_RA, 3);
        wr(A_CTRL, 1);
        ticks(4);
        check("R8 A high before mode change", {31'd0, tioa_out}, 1);
        wr(A_MODE, 0);
        @(negedge clk);
        check("R8 capture outputs low", {30'd0, tioa_out, tiob_out}, 0);
        check("R8 oe low in capture", {31'd0, tioa_oe}, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule